// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the internal algorithm engine of a small flash macro model. It runs byte programming and block erasure on a behavioural non-volatile array kept in flip-flops. A program request carries a byte address and a data byte. An erase request carries a block index. The engine then drives a pulse-and-verify loop, with a bounded number of attempts, on the cells involved. While an erase runs, the engine can park it and let the surrounding logic read the rest of the array. The erase then continues from the point where it stopped.

Programming can only pull bits low. An erase first drives the whole target block to zero and then raises every bit in it, so no cell is left over-erased. The presence of the programming supply arrives as a single input bit and is sampled once per operation. Completion, suspension and the three sticky error conditions appear in an 8-bit status word. A ready/busy pin mirrors the ready state. A test hook can make every verify fail, so that both exhaustion paths can be reached.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset the status word reads 8'h80, the ready/busy pin is high, and every byte of the array reads 8'hFF with the read-valid flag set.
- R2: A program operation stores the old byte ANDed with the new data, so a 0 bit is never turned back into a 1. The byte address is {block index, byte offset}, with the block index in the upper bits.
- R3: A successful erase leaves every byte of the addressed block at 8'hFF and leaves every byte outside that block unchanged.
- R4: An erase drives every byte of its block to 8'h00 before the raising phase begins. If that phase exhausts its attempts, the block is left all zero and the erase error is flagged.
- R5: With no suspension and no failed verify, a program keeps the engine busy for PULSE_CYCLES+2 cycles and an erase for 2*PULSE_CYCLES+3 cycles.
- R6: Each failed verify triggers one more pulse, up to MAX_ATTEMPTS pulses per phase. After the last failure, a program sets the write error and an erase sets the erase error, and the busy time is 1+MAX_ATTEMPTS*(PULSE_CYCLES+1) cycles. The last pulse's effect stays in the array.
- R7: The supply-present input is sampled only in the first busy cycle. If it is low there, the vpp error is set, the array is untouched and the engine is busy for exactly one cycle. If it falls later, the operation is unaffected.
- R8: While an operation runs, status bit 7 and the ready/busy pin are low. Both go high in the cycle in which the one-cycle completion pulse is seen.
- R9: Status bits 5 (erase error), 4 (write error) and 3 (vpp error) are sticky. Only reset clears them, and later successful operations leave them set.
- R10: A suspend request during an erase parks it in the next cycle. Status bit 6 and bit 7 then read 1 and the pin reads high. A resume request continues the same erase to completion.
- R11: Read data is valid when the engine is idle. While an erase is parked, reads outside the parked block are valid and return array data. Reads inside the parked block, and all reads while busy, give read-valid 0 and data 8'h00.
- R12: A suspend and a resume asserted in the same cycle of an erase cause no pause: status bit 6 never rises and the erase takes its normal time.
- R13: Start requests while busy or parked, a suspend during a program, and a resume while not parked have no effect. A program request wins over a simultaneous erase request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startWrite | input | 1 | Request a byte program |
| startErase | input | 1 | Request a block erase |
| wrAddr | input | ADDR_W | Byte address for a program |
| wrData | input | 8 | Data byte for a program |
| eraseBlk | input | BLK_W | Block index for an erase |
| vppOk | input | 1 | Programming supply present |
| suspendReq | input | 1 | Park a running erase |
| resumeReq | input | 1 | Continue a parked erase |
| forceVerifyFail | input | 1 | Test hook that makes every verify fail |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read data, 8'h00 when not valid |
| rdValid | output | 1 | Read data is array content |
| statusReg | output | 8 | {ready, parked, eraseErr, writeErr, vppErr, 3'b000} |
| rdyBusyN | output | 1 | High when ready, low when busy |
| opDone | output | 1 | One-cycle pulse when an operation ends |

## Verification
The hardest states to reach are those inside the erase: the pre-program phase, the point where an erase is parked, and the cycle where suspend and resume collide. None of them is visible at the ports unless the stimulus is timed from the start request. The bench counts busy cycles from the start request and raises suspend, resume, a second start or a supply drop on a chosen busy cycle. Forcing every verify to fail during an erase stops the engine inside the pre-program phase, which exposes that phase as an all-zero block. Sweeps over all 64 bytes, with an AND model and erase model kept in the bench, check the array after each phase.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  // Which algorithm phase the engine is in; the datapath decodes it.
  typedef enum logic [1:0] {
    PH_WRITE   = 2'd0,
    PH_PREPROG = 2'd1,
    PH_ERASE   = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHECK  = 3'd1,
    ST_PULSE  = 3'd2,
    ST_VERIFY = 3'd3,
    ST_SUSP   = 3'd4
  } state_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   latchOp;
    logic   pulseLoad;
    logic   pulseTick;
    logic   applyPulse;
    logic   attemptClr;
    logic   attemptInc;
    phase_e phase;
  } dpStrobe_t;

  // Status word bit positions.
  localparam int SB_READY = 7;
  localparam int SB_SUSP  = 6;
  localparam int SB_ERERR = 5;
  localparam int SB_WRERR = 4;
  localparam int SB_VPP   = 3;

endpackage

// File: rtl/flash_pe_dp.sv
module flash_pe_dp
  import flash_pe_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_BYTES  = 16,
  parameter int MAX_ATTEMPTS = 8,
  parameter int PULSE_CYCLES = 4,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int OFS_W  = $clog2(BLOCK_BYTES),
  localparam int ADDR_W = BLK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic [BLK_W-1:0]  blkIn,
  input  logic              forceFail,
  input  logic              idleNow,
  input  logic              suspNow,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              pulseLast,
  output logic              verifyOk,
  output logic              lastAttempt
);

  localparam int DEPTH = NUM_BLOCKS * BLOCK_BYTES;
  localparam int PC_W  = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam int AT_W  = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic [BLK_W-1:0]  opBlk;
  logic [PC_W-1:0]   pulseCnt;
  logic [AT_W-1:0]   attempts;

  logic [DEPTH-1:0]  cellSel;
  logic [DEPTH-1:0]  zeroOk;
  logic [DEPTH-1:0]  oneOk;

  // Operation registers, captured when a request is accepted.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= 8'hFF;
      opBlk  <= '0;
    end else if (stb.latchOp) begin
      opAddr <= addrIn;
      opData <= dataIn;
      opBlk  <= blkIn;
    end
  end

  // Per-cell block decode and per-cell verify terms.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [BLK_W-1:0] CELL_BLK = BLK_W'(i / BLOCK_BYTES);
    assign cellSel[i] = (opBlk == CELL_BLK);
    assign zeroOk[i]  = !cellSel[i] || (mem[i] == 8'h00);
    assign oneOk[i]   = !cellSel[i] || (mem[i] == 8'hFF);
  end

  // Array update at the end of each pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (stb.applyPulse) begin
      for (int i = 0; i < DEPTH; i++) begin
        unique case (stb.phase)
          PH_WRITE: if (opAddr == ADDR_W'(i)) mem[i] <= mem[i] & opData;
          PH_PREPROG: if (cellSel[i]) mem[i] <= 8'h00;
          PH_ERASE: if (cellSel[i]) mem[i] <= 8'hFF;
          default: ;
        endcase
      end
    end
  end

  // Pulse-width timer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pulseCnt <= '0;
    else if (stb.pulseLoad) pulseCnt <= PC_W'(PULSE_CYCLES - 1);
    else if (stb.pulseTick) pulseCnt <= pulseCnt - 1'b1;
  end
  assign pulseLast = (pulseCnt == '0);

  // Attempt counter: number of failed verifies so far in this phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               attempts <= '0;
    else if (stb.attemptClr) attempts <= '0;
    else if (stb.attemptInc) attempts <= attempts + 1'b1;
  end
  assign lastAttempt = (attempts == AT_W'(MAX_ATTEMPTS - 1));

  // Verify compare for the current phase.
  logic [7:0] wrCell;
  logic       cellsMatch;
  assign wrCell = mem[opAddr];

  always_comb begin
    unique case (stb.phase)
      PH_WRITE:   cellsMatch = ((wrCell & ~opData) == 8'h00);
      PH_PREPROG: cellsMatch = &zeroOk;
      PH_ERASE:   cellsMatch = &oneOk;
      default:    cellsMatch = 1'b0;
    endcase
  end
  assign verifyOk = cellsMatch && !forceFail;

  // Read port: blocked while busy and on a parked block.
  logic [BLK_W-1:0] rdBlk;
  assign rdBlk   = rdAddr[ADDR_W-1 -: BLK_W];
  assign rdValid = idleNow || (suspNow && (rdBlk != opBlk));
  assign rdData  = rdValid ? mem[rdAddr] : 8'h00;

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startWrite,
  input  logic       startErase,
  input  logic       suspendReq,
  input  logic       resumeReq,
  input  logic       vppOk,
  input  logic       pulseLast,
  input  logic       verifyOk,
  input  logic       lastAttempt,
  output dpStrobe_t  stb,
  output logic       idleNow,
  output logic       suspNow,
  output logic [7:0] statusReg,
  output logic       rdyBusyN,
  output logic       opDone
);

  state_e state, stateNx, retState, retNx;
  phase_e phase, phaseNx;
  logic   vppErr, wrErr, erErr;
  logic   setVpp, setWr, setEr, finish;
  logic   isEraseOp, holdReq;

  assign isEraseOp = (phase != PH_WRITE);
  assign holdReq   = isEraseOp && suspendReq && !resumeReq;

  always_comb begin
    stb       = '0;
    stb.phase = phase;
    stateNx   = state;
    phaseNx   = phase;
    retNx     = retState;
    setVpp    = 1'b0;
    setWr     = 1'b0;
    setEr     = 1'b0;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startWrite) begin
          stb.latchOp = 1'b1;
          phaseNx     = PH_WRITE;
          stateNx     = ST_CHECK;
        end else if (startErase) begin
          stb.latchOp = 1'b1;
          phaseNx     = PH_PREPROG;
          stateNx     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!vppOk) begin
          setVpp  = 1'b1;
          finish  = 1'b1;
          stateNx = ST_IDLE;
        end else begin
          stb.pulseLoad  = 1'b1;
          stb.attemptClr = 1'b1;
          stateNx        = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (holdReq) begin
          retNx   = ST_PULSE;
          stateNx = ST_SUSP;
        end else if (pulseLast) begin
          stb.applyPulse = 1'b1;
          stateNx        = ST_VERIFY;
        end else begin
          stb.pulseTick = 1'b1;
        end
      end
      ST_VERIFY: begin
        if (holdReq) begin
          retNx   = ST_VERIFY;
          stateNx = ST_SUSP;
        end else if (verifyOk) begin
          if (phase == PH_PREPROG) begin
            phaseNx        = PH_ERASE;
            stb.attemptClr = 1'b1;
            stb.pulseLoad  = 1'b1;
            stateNx        = ST_PULSE;
          end else begin
            finish  = 1'b1;
            stateNx = ST_IDLE;
          end
        end else if (lastAttempt) begin
          setEr   = isEraseOp;
          setWr   = !isEraseOp;
          finish  = 1'b1;
          stateNx = ST_IDLE;
        end else begin
          stb.attemptInc = 1'b1;
          stb.pulseLoad  = 1'b1;
          stateNx        = ST_PULSE;
        end
      end
      ST_SUSP: begin
        if (resumeReq) stateNx = retState;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retState <= ST_PULSE;
      phase    <= PH_WRITE;
      vppErr   <= 1'b0;
      wrErr    <= 1'b0;
      erErr    <= 1'b0;
      opDone   <= 1'b0;
    end else begin
      state    <= stateNx;
      retState <= retNx;
      phase    <= phaseNx;
      vppErr   <= vppErr | setVpp;
      wrErr    <= wrErr  | setWr;
      erErr    <= erErr  | setEr;
      opDone   <= finish;
    end
  end

  assign idleNow   = (state == ST_IDLE);
  assign suspNow   = (state == ST_SUSP);
  assign rdyBusyN  = idleNow || suspNow;
  assign statusReg = {rdyBusyN, suspNow, erErr, wrErr, vppErr, 3'b000};

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import flash_pe_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_BYTES  = 16,
  parameter int MAX_ATTEMPTS = 8,
  parameter int PULSE_CYCLES = 4,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = BLK_W + $clog2(BLOCK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWrite,
  input  logic              startErase,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [BLK_W-1:0]  eraseBlk,
  input  logic              vppOk,
  input  logic              suspendReq,
  input  logic              resumeReq,
  input  logic              forceVerifyFail,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic [7:0]        statusReg,
  output logic              rdyBusyN,
  output logic              opDone
);

  dpStrobe_t stb;
  logic      idleNow, suspNow, pulseLast, verifyOk, lastAttempt;

  flash_pe_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startWrite  (startWrite),
    .startErase  (startErase),
    .suspendReq  (suspendReq),
    .resumeReq   (resumeReq),
    .vppOk       (vppOk),
    .pulseLast   (pulseLast),
    .verifyOk    (verifyOk),
    .lastAttempt (lastAttempt),
    .stb         (stb),
    .idleNow     (idleNow),
    .suspNow     (suspNow),
    .statusReg   (statusReg),
    .rdyBusyN    (rdyBusyN),
    .opDone      (opDone)
  );

  flash_pe_dp #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .BLOCK_BYTES  (BLOCK_BYTES),
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .addrIn      (wrAddr),
    .dataIn      (wrData),
    .blkIn       (eraseBlk),
    .forceFail   (forceVerifyFail),
    .idleNow     (idleNow),
    .suspNow     (suspNow),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .pulseLast   (pulseLast),
    .verifyOk    (verifyOk),
    .lastAttempt (lastAttempt)
  );

endmodule

// File: rtl/flash_pe_chk.sv
module flash_pe_chk #(
  parameter int MAX_ATTEMPTS = 8,
  parameter int PULSE_CYCLES = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] flags,
  input logic       rdyBusyN,
  input logic       opDone,
  input logic       rdValid
);

  // flags = status bits 7..3: ready, parked, erase err, write err, vpp err
  localparam int unsigned BUSY_LIMIT = 1 + 2 * MAX_ATTEMPTS * (PULSE_CYCLES + 1);

  int unsigned busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busyRun <= 0;
    else if (!flags[4]) busyRun <= busyRun + 1;
    else               busyRun <= 0;
  end

  // R9
  sticky_erase_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[2] |=> flags[2]);
  // R9
  sticky_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[1] |=> flags[1]);
  // R9
  sticky_vpp_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[0] |=> flags[0]);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> (flags[4] && $past(!flags[4])));
  // R10
  parked_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags[3] |-> (flags[4] && rdyBusyN));
  // R11
  busy_noread_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdyBusyN |-> !rdValid);
  // R6
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= BUSY_LIMIT);
  // R7
  vpp_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> opDone);

endmodule

bind flash_pe_engine flash_pe_chk #(
  .MAX_ATTEMPTS (MAX_ATTEMPTS),
  .PULSE_CYCLES (PULSE_CYCLES)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .flags    (statusReg[7:3]),
  .rdyBusyN (rdyBusyN),
  .opDone   (opDone),
  .rdValid  (rdValid)
);

// File: tb/flash_pe_engine_tb_top.sv
module flash_pe_engine_tb_top;
  localparam int NB = 4, BB = 16, MAXA = 8, PC = 4, DEPTH = NB * BB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0;
  logic       startWrite = 0, startErase = 0, vppOk = 1;
  logic       suspendReq = 0, resumeReq = 0, forceVerifyFail = 0;
  logic [5:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] eraseBlk = '0;
  logic [7:0] rdData, statusReg;
  logic       rdValid, rdyBusyN, opDone;

  flash_pe_engine #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .MAX_ATTEMPTS(MAXA),
                    .PULSE_CYCLES(PC)) dut_i (
    .clk(clk), .rstN(rstN), .startWrite(startWrite), .startErase(startErase),
    .wrAddr(wrAddr), .wrData(wrData), .eraseBlk(eraseBlk), .vppOk(vppOk),
    .suspendReq(suspendReq), .resumeReq(resumeReq),
    .forceVerifyFail(forceVerifyFail), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid), .statusReg(statusReg), .rdyBusyN(rdyBusyN),
    .opDone(opDone));

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; startWrite = 0; startErase = 0; suspendReq = 0; resumeReq = 0;
    forceVerifyFail = 0; vppOk = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  task automatic readAt(input int a, output logic [7:0] d, output logic v);
    @(negedge clk);
    rdAddr = a[5:0];
    #1;
    d = rdData;
    v = rdValid;
  endtask

  task automatic checkArray(input string tag);
    logic [7:0] d;
    logic v;
    for (int a = 0; a < DEPTH; a++) begin
      readAt(a, d, v);
      chk(tag, v, 1);
      chk(tag, d, model[a]);
    end
  endtask

  task automatic modelErase(input int b, input logic [7:0] val);
    for (int o = 0; o < BB; o++) model[b * BB + o] = val;
  endtask

  // injKind: 1 = start an erase of block 0 while busy, 2 = drop vppOk
  task automatic runOp(input bit doWr, input bit doEr, input int a, input int d,
                       input int b, input int susAt, input bit susBoth,
                       input int injAt, input int injKind,
                       output int busy, output bit sawSusp);
    @(negedge clk);
    wrAddr = a[5:0]; wrData = d[7:0]; eraseBlk = b[1:0];
    startWrite = doWr; startErase = doEr;
    @(negedge clk);
    startWrite = 0; startErase = 0;
    busy = 0; sawSusp = 0;
    while (statusReg[7] == 1'b0 && busy < 400) begin
      busy++;
      if (busy == 1) begin
        chk("R8 pin low while busy", rdyBusyN, 0);
        chk("R11 no read while busy", rdValid, 0);
      end
      if (statusReg[6]) sawSusp = 1;
      suspendReq = (busy == susAt);
      resumeReq  = (busy == susAt) && susBoth;
      startErase = (injKind == 1) && (busy == injAt);
      if (injKind == 1 && busy == injAt) eraseBlk = 2'd0;
      if (injKind == 2 && busy == injAt) vppOk = 0;
      @(negedge clk);
    end
    suspendReq = 0; resumeReq = 0; startErase = 0;
    chk("R8 done pulse", opDone, 1);
    chk("R8 pin high at end", rdyBusyN, 1);
    @(negedge clk);
    chk("R8 done one cycle", opDone, 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int busy;
    bit ss;
    logic [7:0] d;
    logic v;

    // R1 reset state
    doReset();
    chk("R1 status", statusReg, 8'h80);
    chk("R1 pin", rdyBusyN, 1);
    chk("R1 done", opDone, 0);
    checkArray("R1 array");

    // R2 AND semantics, sweep twice over every byte; R5 program timing
    for (int a = 0; a < DEPTH; a++) begin
      runOp(1, 0, a, (a * 37 + 5) & 255, 0, 0, 0, 0, 0, busy, ss);
      model[a] &= 8'((a * 37 + 5) & 255);
      if (a < 4) chk("R5 program busy", busy, PC + 2);
    end
    for (int a = 0; a < DEPTH; a++) begin
      runOp(1, 0, a, a ^ 8'h5A, 0, 0, 0, 0, 0, busy, ss);
      model[a] &= 8'(a ^ 8'h5A);
    end
    checkArray("R2 and sweep");
    runOp(1, 0, 7, 8'h00, 0, 0, 0, 0, 0, busy, ss);
    runOp(1, 0, 7, 8'hFF, 0, 0, 0, 0, 0, busy, ss);
    model[7] = 8'h00;
    readAt(7, d, v);
    chk("R2 zero stays zero", d, 8'h00);
    chk("R2 no error", statusReg, 8'h80);

    // R3 erase one block; R5 erase timing
    runOp(0, 1, 0, 0, 2, 0, 0, 0, 0, busy, ss);
    modelErase(2, 8'hFF);
    chk("R5 erase busy", busy, 2 * PC + 3);
    checkArray("R3 erase block 2");

    // R13 ignored requests
    runOp(1, 0, 6'h13, 8'h0F, 0, 0, 0, 2, 1, busy, ss);
    model[6'h13] &= 8'h0F;
    chk("R13 start while busy", busy, PC + 2);
    runOp(1, 0, 6'h24, 8'hF0, 0, 2, 0, 0, 0, busy, ss);
    model[6'h24] &= 8'hF0;
    chk("R13 suspend in program busy", busy, PC + 2);
    chk("R13 suspend in program parked", ss, 0);
    runOp(1, 1, 6'h14, 8'h3C, 1, 0, 0, 0, 0, busy, ss);
    model[6'h14] &= 8'h3C;
    chk("R13 program wins", busy, PC + 2);
    @(negedge clk); resumeReq = 1;
    @(negedge clk); resumeReq = 0;
    @(negedge clk);
    chk("R13 resume while idle", statusReg, 8'h80);
    checkArray("R13 array");

    // R12 same-cycle suspend and resume during an erase
    runOp(0, 1, 0, 0, 1, 3, 1, 0, 0, busy, ss);
    modelErase(1, 8'hFF);
    chk("R12 no pause busy", busy, 2 * PC + 3);
    chk("R12 never parked", ss, 0);

    // R10 / R11 parked erase
    runOp(1, 0, 6'h02, 8'h3C, 0, 0, 0, 0, 0, busy, ss);
    model[2] &= 8'h3C;
    runOp(1, 0, 6'h31, 8'h00, 0, 0, 0, 0, 0, busy, ss);
    model[6'h31] = 8'h00;
    @(negedge clk);
    eraseBlk = 2'd3; startErase = 1;
    @(negedge clk); startErase = 0;
    repeat (3) @(negedge clk);
    suspendReq = 1;
    @(negedge clk); suspendReq = 0;
    chk("R10 parked bit", statusReg[6], 1);
    chk("R10 ready bit", statusReg[7], 1);
    chk("R10 pin high", rdyBusyN, 1);
    readAt(2, d, v);
    chk("R11 other block valid", v, 1);
    chk("R11 other block data", d, model[2]);
    readAt(6'h31, d, v);
    chk("R11 parked block invalid", v, 0);
    chk("R11 parked block data", d, 8'h00);
    @(negedge clk);
    wrAddr = 6'h05; wrData = 8'h00; startWrite = 1;
    @(negedge clk); startWrite = 0;
    repeat (2) @(negedge clk);
    chk("R13 start while parked", statusReg[6], 1);
    resumeReq = 1;
    @(negedge clk); resumeReq = 0;
    chk("R10 resumed busy", statusReg[7], 0);
    busy = 0;
    while (statusReg[7] == 1'b0 && busy < 400) begin
      busy++;
      @(negedge clk);
    end
    chk("R10 resumed done", opDone, 1);
    modelErase(3, 8'hFF);
    checkArray("R10 erase after resume");

    // R7 supply falls after sampling
    runOp(1, 0, 6'h0A, 8'h81, 0, 0, 0, 3, 2, busy, ss);
    vppOk = 1;
    model[6'h0A] &= 8'h81;
    chk("R7 late drop busy", busy, PC + 2);
    chk("R7 late drop status", statusReg, 8'h80);
    // R7 supply absent at sampling
    vppOk = 0;
    runOp(1, 0, 6'h10, 8'h00, 0, 0, 0, 0, 0, busy, ss);
    vppOk = 1;
    chk("R7 vpp busy", busy, 1);
    chk("R7 vpp status", statusReg, 8'h88);
    readAt(6'h10, d, v);
    chk("R7 array untouched", d, model[6'h10]);
    // R9 sticky across later good operations
    runOp(1, 0, 6'h10, 8'h7E, 0, 0, 0, 0, 0, busy, ss);
    model[6'h10] &= 8'h7E;
    chk("R9 vpp sticky", statusReg, 8'h88);
    checkArray("R9 array");

    // R6 program exhausts attempts
    doReset();
    chk("R9 reset clears", statusReg, 8'h80);
    forceVerifyFail = 1;
    runOp(1, 0, 6'h21, 8'hA5, 0, 0, 0, 0, 0, busy, ss);
    forceVerifyFail = 0;
    model[6'h21] &= 8'hA5;
    chk("R6 program fail busy", busy, 1 + MAXA * (PC + 1));
    chk("R6 program fail status", statusReg, 8'h90);
    checkArray("R6 program fail array");

    // R4 / R6 erase exhausts attempts in the pre-program phase
    doReset();
    runOp(1, 0, 6'h15, 8'h77, 0, 0, 0, 0, 0, busy, ss);
    model[6'h15] = 8'h77;
    runOp(1, 0, 6'h25, 8'h08, 0, 0, 0, 0, 0, busy, ss);
    model[6'h25] = 8'h08;
    forceVerifyFail = 1;
    runOp(0, 1, 0, 0, 1, 0, 0, 0, 0, busy, ss);
    forceVerifyFail = 0;
    modelErase(1, 8'h00);
    chk("R6 erase fail busy", busy, 1 + MAXA * (PC + 1));
    chk("R4 erase fail status", statusReg, 8'hA0);
    checkArray("R4 block zeroed first");
    runOp(0, 1, 0, 0, 1, 0, 0, 0, 0, busy, ss);
    modelErase(1, 8'hFF);
    chk("R9 erase err sticky", statusReg, 8'hA0);
    checkArray("R3 erase after fail");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule